// File: doc/BRIEF.md
# Register Access Engine with Error Retry

This block masters a shared peripheral register bus on behalf of one client. The client hands it a single register access: a unit number, a register number, a direction and, for a write, a 16-bit data word. The engine turns that into bus operations. A write is one register-load operation. A read first sends a register-select operation, then leaves the bus quiet for a set number of settling cycles, and then fetches the data word.

When an attempt has finished, the engine looks at the bus's access-error status. If that status is set, the engine sends a control word that clears the error and keeps the bus enabled, and then runs the whole attempt again. The number of repeats has an upper bound. If any attempt failed, one more clearing control word goes out before the result is returned, whether or not the retries succeeded. The response carries the masked read data and a flag that shows whether the final attempt still saw an error.

The bus side uses a plain valid/acknowledge model. An operation's fields stay on the bus until `bus_ack` is seen high at a clock edge. Requests and responses use valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high. A response is held, unchanged, until `rsp_ready` is high. Only one access can be in flight at a time, so `req_ready` works as back-pressure for the whole time an access is running.

Top module: `regacc_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1 and `bus_valid` and `rsp_valid` are 0.
- R2: `req_ready` is high only when no access is in flight. It drops in the cycle after a request is accepted and stays low until the response handshake completes.
- R3: Every bus operation has `bus_intdis` = 1 and `bus_unit` equal to the requested unit. Register operations (codes 00 and 01) carry the requested register on `bus_reg`. Control operations (code 10) carry 0 on `bus_reg`.
- R4: The encoding of `bus_op` is 00 for register load/select, 01 for data fetch and 10 for control. A write attempt is one op 00 with `bus_load` = 1 and `bus_wdata` set to the write data. A read attempt is one op 00 with `bus_load` = 0 and `bus_wdata` = 0, then exactly SETTLE_CYC cycles with `bus_valid` low, then one op 01.
- R5: A read response returns bits [15:0] of `bus_rdata` as they stood when the last attempt's op 01 was acknowledged; any higher bits are dropped. A write response returns 0 data.
- R6: `bus_acc_err` is sampled one cycle after the acknowledge that ends an attempt. If it is 1 and retries remain, the engine issues op 10 with `bus_wdata` = 0x0003 (bit 1 bus enable, bit 0 error clear) and `bus_load` = 0, and then repeats the whole attempt from its first operation.
- R7: At most MAX_RETRY (default 10) repeats follow the first failure, so an access makes at most MAX_RETRY+1 attempts.
- R8: If any attempt of an access saw an error, one final op 10 with word 0x0003 is issued after the last attempt and before the response. If no attempt saw an error, no control operation is issued.
- R9: `rsp_err` is the error status of the last attempt. It is 1 only when every allowed attempt failed.
- R10: Once `bus_valid` is high, it stays high with all bus fields unchanged until `bus_ack`. Once `rsp_valid` is high, it stays high with `rsp_rdata` and `rsp_err` unchanged until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_unit | input | UNIT_W | Target unit number |
| req_reg | input | REG_W | Target register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Client takes response |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| rsp_err | output | 1 | Last attempt still had an access error |
| bus_valid | output | 1 | Bus operation presented |
| bus_ack | input | 1 | Bus accepts the presented operation |
| bus_op | output | 2 | 00 load/select, 01 fetch, 10 control |
| bus_unit | output | UNIT_W | Unit select field |
| bus_reg | output | REG_W | Register select field |
| bus_load | output | 1 | Register-load flag (writes) |
| bus_intdis | output | 1 | Access-error interrupt disable |
| bus_wdata | output | DATA_W | Data or control word |
| bus_rdata | input | RAW_W | Raw fetched data |
| bus_acc_err | input | 1 | Access-error status |

## Verification
A wrong state or a wrong retry count would show up at the bus port as soon as the engine's next operation appears. A corrupted state shows as a missing or extra control word, an op 00 where an op 01 belongs, or a retry that starts without a clear first. A settling counter that is off by one cycle changes the quiet gap before the fetch, and that gap is measured on every read attempt. Errors in the captured registers reach the ports later: a wrong unit or register field shows on the first operation, but wrong data capture or a wrong error flag shows only at the response.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_FETCH = 2'b01,
    OP_CTRL  = 2'b10
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_XFER,
    S_SETTLE,
    S_FETCH,
    S_CHECK,
    S_CLR_RETRY,
    S_CLR_FINAL,
    S_RESP
  } eng_state_e;

  localparam int unsigned CTRL_ENABLE_BIT = 1;
  localparam int unsigned CTRL_CLEAR_BIT  = 0;

endpackage

// File: rtl/regacc_settle_timer.sv
module regacc_settle_timer #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  // Load CYCLES-1 when the select is acknowledged; count down while waiting.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(CYCLES - 1);
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = run && (cnt_q == '0);
endmodule

// File: rtl/regacc_retry_ctr.sv
module regacc_retry_ctr #(
  parameter int unsigned MAX_RETRY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic spent
);
  localparam int unsigned RW = $clog2(MAX_RETRY + 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != RW'(MAX_RETRY))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign spent = (cnt_q == RW'(MAX_RETRY));
endmodule

// File: rtl/regacc_bus_fmt.sv
module regacc_bus_fmt
  import regacc_pkg::*;
#(
  parameter int unsigned UNIT_W = 3,
  parameter int unsigned REG_W  = 6,
  parameter int unsigned DATA_W = 16
) (
  input  eng_state_e        state,
  input  logic [UNIT_W-1:0] unit_q,
  input  logic [REG_W-1:0]  reg_q,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic              bus_valid,
  output logic [1:0]        bus_op,
  output logic [UNIT_W-1:0] bus_unit,
  output logic [REG_W-1:0]  bus_reg,
  output logic              bus_load,
  output logic              bus_intdis,
  output logic [DATA_W-1:0] bus_wdata
);
  logic [DATA_W-1:0] ctrl_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_ENABLE_BIT] = 1'b1;
    ctrl_word[CTRL_CLEAR_BIT]  = 1'b1;
  end

  always_comb begin
    bus_valid  = 1'b0;
    bus_op     = OP_LOAD;
    bus_unit   = '0;
    bus_reg    = '0;
    bus_load   = 1'b0;
    bus_intdis = 1'b0;
    bus_wdata  = '0;
    unique case (state)
      S_XFER: begin
        bus_valid  = 1'b1;
        bus_op     = OP_LOAD;
        bus_unit   = unit_q;
        bus_reg    = reg_q;
        bus_load   = wr_q;
        bus_intdis = 1'b1;
        bus_wdata  = wr_q ? wdata_q : '0;
      end
      S_FETCH: begin
        bus_valid  = 1'b1;
        bus_op     = OP_FETCH;
        bus_unit   = unit_q;
        bus_reg    = reg_q;
        bus_intdis = 1'b1;
      end
      S_CLR_RETRY, S_CLR_FINAL: begin
        bus_valid  = 1'b1;
        bus_op     = OP_CTRL;
        bus_unit   = unit_q;
        bus_intdis = 1'b1;
        bus_wdata  = ctrl_word;
      end
      default: begin
        bus_valid = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/regacc_engine.sv
module regacc_engine
  import regacc_pkg::*;
#(
  parameter int unsigned UNIT_W     = 3,
  parameter int unsigned REG_W      = 6,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned RAW_W      = 18,
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned MAX_RETRY  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [UNIT_W-1:0] req_unit,
  input  logic [REG_W-1:0]  req_reg,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_valid,
  input  logic              bus_ack,
  output logic [1:0]        bus_op,
  output logic [UNIT_W-1:0] bus_unit,
  output logic [REG_W-1:0]  bus_reg,
  output logic              bus_load,
  output logic              bus_intdis,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [RAW_W-1:0]  bus_rdata,
  input  logic              bus_acc_err
);
  if (SETTLE_CYC < 2) begin : g_bad_settle
    $error("regacc_engine: SETTLE_CYC must be at least 2");
  end

  if (RAW_W > DATA_W) begin : g_drop_hi
    logic unused_raw_hi;
    assign unused_raw_hi = ^bus_rdata[RAW_W-1:DATA_W];
  end

  eng_state_e        state_q, state_d;
  logic [UNIT_W-1:0] unit_q;
  logic [REG_W-1:0]  reg_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_seen_q;
  logic              last_err_q;

  logic accept;
  logic settle_start;
  logic settle_done;
  logic retry_inc;
  logic retry_spent;

  assign req_ready    = (state_q == S_IDLE);
  assign rsp_valid    = (state_q == S_RESP);
  assign accept       = req_valid && req_ready;
  assign settle_start = (state_q == S_XFER) && bus_ack && !wr_q;
  assign retry_inc    = (state_q == S_CLR_RETRY) && bus_ack;

  regacc_settle_timer #(
    .CYCLES(SETTLE_CYC)
  ) settle_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(settle_start),
    .run  (state_q == S_SETTLE),
    .done (settle_done)
  );

  regacc_retry_ctr #(
    .MAX_RETRY(MAX_RETRY)
  ) retry_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .inc  (retry_inc),
    .spent(retry_spent)
  );

  regacc_bus_fmt #(
    .UNIT_W(UNIT_W),
    .REG_W (REG_W),
    .DATA_W(DATA_W)
  ) fmt_i (
    .state     (state_q),
    .unit_q    (unit_q),
    .reg_q     (reg_q),
    .wr_q      (wr_q),
    .wdata_q   (wdata_q),
    .bus_valid (bus_valid),
    .bus_op    (bus_op),
    .bus_unit  (bus_unit),
    .bus_reg   (bus_reg),
    .bus_load  (bus_load),
    .bus_intdis(bus_intdis),
    .bus_wdata (bus_wdata)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (req_valid) state_d = S_XFER;
      S_XFER:      if (bus_ack) state_d = wr_q ? S_CHECK : S_SETTLE;
      S_SETTLE:    if (settle_done) state_d = S_FETCH;
      S_FETCH:     if (bus_ack) state_d = S_CHECK;
      S_CHECK: begin
        if (bus_acc_err) begin
          state_d = retry_spent ? S_CLR_FINAL : S_CLR_RETRY;
        end else begin
          state_d = err_seen_q ? S_CLR_FINAL : S_RESP;
        end
      end
      S_CLR_RETRY: if (bus_ack) state_d = S_XFER;
      S_CLR_FINAL: if (bus_ack) state_d = S_RESP;
      S_RESP:      if (rsp_ready) state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_q     <= '0;
      reg_q      <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      err_seen_q <= 1'b0;
      last_err_q <= 1'b0;
    end else begin
      if (accept) begin
        unit_q     <= req_unit;
        reg_q      <= req_reg;
        wr_q       <= req_write;
        wdata_q    <= req_wdata;
        rdata_q    <= '0;
        err_seen_q <= 1'b0;
        last_err_q <= 1'b0;
      end
      if ((state_q == S_FETCH) && bus_ack) begin
        rdata_q <= bus_rdata[DATA_W-1:0];
      end
      if (state_q == S_CHECK) begin
        last_err_q <= bus_acc_err;
        if (bus_acc_err) begin
          err_seen_q <= 1'b1;
        end
      end
    end
  end

  assign rsp_rdata = rdata_q;
  assign rsp_err   = last_err_q;
endmodule

// File: rtl/regacc_engine_chk.sv
module regacc_engine_chk #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned MAX_RETRY  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              bus_valid,
  input logic              bus_ack,
  input logic [1:0]        bus_op,
  input logic              bus_load,
  input logic              bus_intdis,
  input logic [DATA_W-1:0] bus_wdata
);
  localparam int unsigned AW = $clog2(MAX_RETRY + 3);
  localparam int unsigned GW = $clog2(SETTLE_CYC + 3);

  logic [AW-1:0] att_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_cnt <= '0;
    end else if (req_valid && req_ready) begin
      att_cnt <= '0;
    end else if (bus_valid && bus_ack && (bus_op == 2'b00) && (att_cnt != '1)) begin
      att_cnt <= att_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (bus_valid && bus_ack && (bus_op == 2'b00)) begin
      gap_cnt <= '0;
    end else if (!bus_valid && (gap_cnt != '1)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !bus_valid && !rsp_valid));

  p_single_flight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_valid && !rsp_valid));

  p_intdis_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_intdis);

  p_settle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_valid) && (bus_op == 2'b01)) |-> (gap_cnt == GW'(SETTLE_CYC)));

  p_ctrl_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_op == 2'b10)) |-> ((bus_wdata == DATA_W'(3)) && !bus_load));

  p_attempt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_op == 2'b00)) |-> (att_cnt <= AW'(MAX_RETRY)));

  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_op) && $stable(bus_wdata) && $stable(bus_load)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

bind regacc_engine regacc_engine_chk #(
  .DATA_W    (DATA_W),
  .SETTLE_CYC(SETTLE_CYC),
  .MAX_RETRY (MAX_RETRY)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .bus_valid (bus_valid),
  .bus_ack   (bus_ack),
  .bus_op    (bus_op),
  .bus_load  (bus_load),
  .bus_intdis(bus_intdis),
  .bus_wdata (bus_wdata)
);

// File: tb/regacc_engine_tb_top.sv
module regacc_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT_W = 3;
  localparam int REG_W  = 6;
  localparam int DATA_W = 16;
  localparam int RAW_W  = 18;
  localparam int SETTLE = 3;
  localparam int MAXR   = 10;
  localparam int WDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [UNIT_W-1:0] req_unit = '0;
  logic [REG_W-1:0]  req_reg = '0;
  logic              req_write = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_err;
  logic              bus_valid;
  logic              bus_ack = 1'b0;
  logic [1:0]        bus_op;
  logic [UNIT_W-1:0] bus_unit;
  logic [REG_W-1:0]  bus_reg;
  logic              bus_load;
  logic              bus_intdis;
  logic [DATA_W-1:0] bus_wdata;
  logic [RAW_W-1:0]  bus_rdata = '0;
  logic              bus_acc_err = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model state
  int q_op[$];
  int q_reg[$];
  int q_load[$];
  int q_wd[$];
  int cur_unit = 0;
  int cur_fails = 0;
  int ack_dly = 0;
  int rd_base = 0;
  int att_idx = 0;
  int wait_c = 0;
  bit gap_on = 1'b0;
  int gap = 0;
  bit busy_m = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regacc_engine #(
    .UNIT_W(UNIT_W), .REG_W(REG_W), .DATA_W(DATA_W), .RAW_W(RAW_W),
    .SETTLE_CYC(SETTLE), .MAX_RETRY(MAXR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_unit(req_unit),
    .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .bus_valid(bus_valid), .bus_ack(bus_ack),
    .bus_op(bus_op), .bus_unit(bus_unit), .bus_reg(bus_reg),
    .bus_load(bus_load), .bus_intdis(bus_intdis), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_acc_err(bus_acc_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Occupancy model: busy from request handshake to response handshake.
  always @(posedge clk) begin
    if (!rst_n) busy_m <= 1'b0;
    else if (req_valid && req_ready) busy_m <= 1'b1;
    else if (rsp_valid && rsp_ready) busy_m <= 1'b0;
  end

  // Per-clock comparison, well away from the active edge.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(req_ready == !busy_m, "R2 req_ready vs model", req_ready, !busy_m);
      if (rsp_valid) chk(q_op.size() == 0, "R8 ops left at response", q_op.size(), 0);
    end
  end

  // Bus responder and operation scoreboard.
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
      wait_c = 0;
    end else begin
      if (req_valid && req_ready) att_idx = 0;
      if (gap_on) begin
        if (!bus_valid) gap++;
        else begin
          chk(bus_op == 2'b01 && gap == SETTLE, "R4 settle gap", gap, SETTLE);
          gap_on = 1'b0;
        end
      end
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_valid) begin
        if (wait_c < ack_dly) begin
          wait_c++;
        end else begin
          wait_c = 0;
          bus_ack = 1'b1;
          chk(bus_intdis == 1'b1, "R3 intdis", bus_intdis, 1);
          chk(bus_unit == UNIT_W'(cur_unit), "R3 unit", bus_unit, cur_unit);
          if (q_op.size() == 0) begin
            chk(1'b0, "R7 unexpected extra op", bus_op, 3);
          end else begin
            chk(bus_op == 2'(q_op[0]), "R6 op order", bus_op, q_op[0]);
            chk(bus_reg == REG_W'(q_reg[0]), "R3 reg field", bus_reg, q_reg[0]);
            chk(bus_load == q_load[0][0], "R4 load flag", bus_load, q_load[0]);
            chk(bus_wdata == DATA_W'(q_wd[0]), "R4 R6 data word", bus_wdata, q_wd[0]);
            void'(q_op.pop_front()); void'(q_reg.pop_front());
            void'(q_load.pop_front()); void'(q_wd.pop_front());
          end
          if (bus_op == 2'b10) begin
            bus_acc_err = 1'b0;
          end else if (bus_op == 2'b01 || (bus_op == 2'b00 && bus_load)) begin
            if (bus_op == 2'b01)
              bus_rdata = {2'b11, 16'(rd_base + att_idx)};
            bus_acc_err = (att_idx < cur_fails);
            att_idx++;
          end else begin
            gap_on = 1'b1;
            gap = 0;
          end
        end
      end
    end
  end

  task automatic push_op(input int op, input int rg, input int ld, input int wd);
    q_op.push_back(op); q_reg.push_back(rg); q_load.push_back(ld); q_wd.push_back(wd);
  endtask

  task automatic access(input bit wr, input int unit, input int rg, input int wd,
                        input int fails, input int dly, input int bp, input int base);
    int att;
    int exp_rd;
    bit exp_err;
    logic [DATA_W-1:0] hold_d;
    logic hold_e;
    att = (fails > MAXR) ? MAXR + 1 : fails + 1;
    exp_err = (fails > MAXR);
    exp_rd = wr ? 0 : ((base + att - 1) & 16'hFFFF);
    for (int k = 0; k < att; k++) begin
      if (k > 0) push_op(2, 0, 0, 3);
      if (wr) push_op(0, rg, 1, wd);
      else begin
        push_op(0, rg, 0, 0);
        push_op(1, rg, 0, 0);
      end
    end
    if (fails > 0) push_op(2, 0, 0, 3);
    cur_unit = unit; cur_fails = fails; ack_dly = dly; rd_base = base;
    @(negedge clk);
    req_unit = UNIT_W'(unit); req_reg = REG_W'(rg); req_write = wr;
    req_wdata = DATA_W'(wd); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    hold_d = rsp_rdata; hold_e = rsp_err;
    for (int i = 0; i < bp; i++) @(negedge clk);
    if (bp > 0)
      chk(rsp_valid && rsp_rdata == hold_d && rsp_err == hold_e, "R10 response hold", rsp_rdata, hold_d);
    chk(rsp_rdata == DATA_W'(exp_rd), "R5 response data", rsp_rdata, exp_rd);
    chk(rsp_err == exp_err, "R9 response error flag", rsp_err, exp_err);
    chk(att_idx == att, "R7 attempt count", att_idx, att);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R10 response released", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_valid, "R1 reset state", {req_ready, bus_valid, rsp_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_valid, "R1 after release", {req_ready, bus_valid, rsp_valid}, 3'b100);
    access(1'b1, 2, 5, 16'hBEEF, 0, 0, 0, 0);        // R4 clean write
    access(1'b0, 3, 18, 0, 0, 2, 0, 16'h1230);       // R4 R5 clean read
    access(1'b0, 1, 40, 0, 1, 1, 2, 16'hA000);       // R6 R8 one failure
    access(1'b1, 6, 9, 16'h5A5A, 3, 0, 0, 0);        // R6 write retries
    access(1'b0, 4, 33, 0, 10, 0, 1, 16'hFFFE);      // R7 last retry succeeds
    access(1'b0, 5, 2, 0, 11, 1, 0, 16'h0100);       // R7 R9 retries exhausted
    access(1'b1, 0, 63, 16'h0001, 15, 0, 0, 0);      // R7 R9 write exhausted
    access(1'b0, 7, 63, 0, 0, 0, 3, 16'h7FFF);       // R10 back-pressure
    repeat (4) @(negedge clk);
    chk(q_op.size() == 0 && !bus_valid, "R8 no stray ops", q_op.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired: cycles=%0d expected < %0d", WDOG, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule